// File: doc/BRIEF.md
# Codec Mode-Change and Calibration Sequencer

This block is the control sequencer that sits behind an audio codec's indexed register port. It holds a small configuration register with a mode-change-enable flag and an autocalibrate-enable flag. It also holds the clock-select and frequency-select registers. It decides when the converters' offset calibration runs and whether the stored offset values are refreshed or kept. A calibration starts by itself when reset is released. It starts again whenever software clears the mode-change-enable flag while autocalibration is enabled. While a calibration is pending or running, the block holds off data transfers, flags ADC output as invalid and tells the DAC path to discard its input.

Any write to the clock-select register starts a resynchronization busy period. During that period every read returns the busy code 0x80 and every write is dropped. When mode-change-enable is set, the busy period is counted in sample periods. On the direct path (mode-change-enable clear) it is counted in microsecond ticks, and a skip-wait flag can remove it altogether. In the expanded mode, with frequency-enable set, the two frequency-select bytes can be rewritten on the fly without any busy period. The `sp_strobe` input pulses once per audio sample period, and `us_tick` pulses once per microsecond. Both are single-cycle strobes. All pins are plain control and status signals, so there is no valid/ready handshake and no back-pressure. A register write takes effect on the clock edge where `reg_wr` is high, and `reg_rdata` follows `reg_idx` combinationally.

Top module: `codec_modecal_seq`

## Requirements
- R1: After reset the configuration register (index 0) reads 0x03: bit 0 is mode-change-enable and bit 1 is autocalibrate-enable, and both are set. A calibration is scheduled with no software action.
- R2: A write to index 0 that takes bit 0 from 1 to 0 schedules a calibration when bit 1 of the written data is 1. When bit 1 of the written data is 0, no calibration runs and no offset load strobe is issued, so the stored offsets are kept.
- R3: `cal_busy` rises on the 3rd sample strobe after the trigger, which is within the 5-period limit. It stays high for exactly 384 sample strobes and then falls.
- R4: `xfer_hold` is high from the trigger until `cal_busy` falls.
- R5: `adc_invalid` and `dac_ignore` are high whenever `cal_busy` is high.
- R6: One write to index 1 sets the clock divide select (bits 2:0, output `clk_div`) and the clock source select (bit 3, output `clk_src`) together. Reading index 1 returns {4'b0, source, divide}.
- R7: During resynchronization every read returns 0x80 at any index, and register writes are dropped. This includes a write that would otherwise start a calibration.
- R8: When mode-change-enable is 1, a clock write starts a resynchronization lasting 64 sample strobes.
- R9: When mode-change-enable is 0, a clock write starts a resynchronization lasting 200 microsecond ticks. If skip-wait (configuration bit 2) is 1, there is no resynchronization at all.
- R10: `ofs_load` pulses for one cycle, together with the falling edge of `cal_busy`, at the end of each calibration.
- R11: Index 2 (upper byte) and index 3 (lower byte) of `freq_word` are written only when configuration bits 3 (expanded mode) and 4 (frequency-enable) are both 1. Otherwise those writes are ignored. These writes never cause a busy period.
- R12: A trigger that arrives while a calibration is pending or running is ignored. Index 4 reads {6'b0, pending, busy}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| sp_strobe | input | 1 | One-cycle pulse per sample period |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| reg_wr | input | 1 | Register write enable |
| reg_idx | input | 3 | Register index |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_idx`, 0x80 while resynchronizing |
| clk_div | output | 3 | Clock divide select |
| clk_src | output | 1 | Clock source select |
| freq_word | output | 16 | Upper and lower frequency-select bytes |
| cal_busy | output | 1 | Calibration in progress |
| xfer_hold | output | 1 | Hold off data transfers |
| dac_ignore | output | 1 | Discard DAC input samples |
| adc_invalid | output | 1 | ADC output data invalid |
| ofs_load | output | 1 | Refresh stored offsets (one-cycle pulse) |

## Verification
The bench measures the start delay and the busy length in counted sample strobes. A design with an off-by-one counter would report 2, 4, 383 or 385 strobes instead of 3 and 384. A write that clears mode-change-enable during resynchronization must not start a calibration. A design that decodes writes while busy would change the configuration and raise `cal_busy`. The direct-path busy period is timed in microsecond ticks against the skip-wait case, which catches a design that uses the wrong time base or ignores the skip flag. Randomized frequency writes under random mode bits catch writes that leak through when either enable is clear. A repeated trigger during a running calibration catches a design that restarts and issues a second offset load.

// File: rtl/codec_seq_pkg.sv
package codec_seq_pkg;
  localparam logic [2:0] IDX_CFG  = 3'd0;
  localparam logic [2:0] IDX_CLK  = 3'd1;
  localparam logic [2:0] IDX_FHI  = 3'd2;
  localparam logic [2:0] IDX_FLO  = 3'd3;
  localparam logic [2:0] IDX_STAT = 3'd4;

  localparam int CFG_MCE   = 0;
  localparam int CFG_ACAL  = 1;
  localparam int CFG_SKIP  = 2;
  localparam int CFG_XMODE = 3;
  localparam int CFG_FREN  = 4;
  localparam int CFG_W     = 5;

  localparam logic [CFG_W-1:0] CFG_RESET = 5'b00011;
  localparam logic [7:0]       BUSY_CODE = 8'h80;

  typedef enum logic [1:0] {
    CAL_IDLE = 2'd0,
    CAL_WAIT = 2'd1,
    CAL_RUN  = 2'd2
  } cal_st_e;
endpackage

// File: rtl/codec_cal_seq.sv
module codec_cal_seq
  import codec_seq_pkg::*;
#(
  parameter int START_DLY = 3,
  parameter int CAL_LEN   = 384
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  input  logic sp_strobe,
  output logic busy,
  output logic pending,
  output logic done_pulse
);
  localparam int DW = $clog2(START_DLY + 1);
  localparam int LW = $clog2(CAL_LEN + 1);
  localparam logic [DW-1:0] DLY_LAST = DW'(START_DLY - 1);
  localparam logic [LW-1:0] LEN_INIT = LW'(CAL_LEN);

  cal_st_e       st_q;
  logic [DW-1:0] dly_q;
  logic [LW-1:0] len_q;

  // Reset lands in the wait state: the power-up calibration needs no trigger.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= CAL_WAIT;
      dly_q      <= '0;
      len_q      <= '0;
      done_pulse <= 1'b0;
    end else begin
      done_pulse <= 1'b0;
      unique case (st_q)
        CAL_IDLE: begin
          if (trig) begin
            st_q  <= CAL_WAIT;
            dly_q <= '0;
          end
        end
        CAL_WAIT: begin
          if (sp_strobe) begin
            if (dly_q == DLY_LAST) begin
              st_q  <= CAL_RUN;
              len_q <= LEN_INIT;
            end else begin
              dly_q <= dly_q + 1'b1;
            end
          end
        end
        CAL_RUN: begin
          if (sp_strobe) begin
            if (len_q == LW'(1)) begin
              st_q       <= CAL_IDLE;
              done_pulse <= 1'b1;
            end else begin
              len_q <= len_q - 1'b1;
            end
          end
        end
        default: st_q <= CAL_IDLE;
      endcase
    end
  end

  assign busy    = (st_q == CAL_RUN);
  assign pending = (st_q != CAL_IDLE);
endmodule

// File: rtl/codec_resync_timer.sv
module codec_resync_timer #(
  parameter int SP_LEN = 64,
  parameter int US_LEN = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic use_us,
  input  logic sp_strobe,
  input  logic us_tick,
  output logic busy
);
  localparam int MAXLEN = (SP_LEN > US_LEN) ? SP_LEN : US_LEN;
  localparam int CW     = $clog2(MAXLEN + 1);

  logic          busy_q;
  logic          us_mode_q;
  logic [CW-1:0] cnt_q;
  logic          step;

  assign step = us_mode_q ? us_tick : sp_strobe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      us_mode_q <= 1'b0;
      cnt_q     <= '0;
    end else if (start) begin
      busy_q    <= 1'b1;
      us_mode_q <= use_us;
      cnt_q     <= use_us ? CW'(US_LEN) : CW'(SP_LEN);
    end else if (busy_q && step) begin
      if (cnt_q == CW'(1)) busy_q <= 1'b0;
      else                 cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign busy = busy_q;
endmodule

// File: rtl/codec_seq_regs.sv
module codec_seq_regs
  import codec_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       idx,
  input  logic [7:0]       wdata,
  input  logic             rs_busy,
  input  logic             cal_busy,
  input  logic             cal_pend,
  output logic [7:0]       rdata,
  output logic [CFG_W-1:0] cfg_q,
  output logic [3:0]       clk_q,
  output logic [15:0]      freq_q,
  output logic             rs_start,
  output logic             rs_use_us,
  output logic             cal_trig
);
  logic wr_ok;
  logic freq_ok;
  logic no_wait;

  assign wr_ok     = wr_en && !rs_busy;
  assign freq_ok   = cfg_q[CFG_XMODE] && cfg_q[CFG_FREN];
  assign rs_use_us = !cfg_q[CFG_MCE];
  assign no_wait   = !cfg_q[CFG_MCE] && cfg_q[CFG_SKIP];

  always_comb begin
    rs_start = wr_ok && (idx == IDX_CLK) && !no_wait;
    cal_trig = wr_ok && (idx == IDX_CFG) && cfg_q[CFG_MCE]
               && !wdata[CFG_MCE] && wdata[CFG_ACAL];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= CFG_RESET;
      clk_q  <= '0;
      freq_q <= '0;
    end else if (wr_ok) begin
      unique case (idx)
        IDX_CFG: cfg_q <= wdata[CFG_W-1:0];
        IDX_CLK: clk_q <= wdata[3:0];
        IDX_FHI: if (freq_ok) freq_q[15:8] <= wdata;
        IDX_FLO: if (freq_ok) freq_q[7:0]  <= wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    if (rs_busy) begin
      rdata = BUSY_CODE;
    end else begin
      unique case (idx)
        IDX_CFG:  rdata = {{(8-CFG_W){1'b0}}, cfg_q};
        IDX_CLK:  rdata = {4'b0, clk_q};
        IDX_FHI:  rdata = freq_q[15:8];
        IDX_FLO:  rdata = freq_q[7:0];
        IDX_STAT: rdata = {6'b0, cal_pend, cal_busy};
        default:  rdata = 8'h00;
      endcase
    end
  end
endmodule

// File: rtl/codec_modecal_seq.sv
module codec_modecal_seq
  import codec_seq_pkg::*;
#(
  parameter int START_DLY = 3,
  parameter int CAL_LEN   = 384,
  parameter int RESYNC_SP = 64,
  parameter int DIRECT_US = 200
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sp_strobe,
  input  logic        us_tick,
  input  logic        reg_wr,
  input  logic [2:0]  reg_idx,
  input  logic [7:0]  reg_wdata,
  output logic [7:0]  reg_rdata,
  output logic [2:0]  clk_div,
  output logic        clk_src,
  output logic [15:0] freq_word,
  output logic        cal_busy,
  output logic        xfer_hold,
  output logic        dac_ignore,
  output logic        adc_invalid,
  output logic        ofs_load
);
  logic [CFG_W-1:0] cfg_q;
  logic [3:0]       clk_q;
  logic             rs_busy, rs_start, rs_use_us;
  logic             cal_trig, cal_pend;

  codec_seq_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (reg_wr),
    .idx      (reg_idx),
    .wdata    (reg_wdata),
    .rs_busy  (rs_busy),
    .cal_busy (cal_busy),
    .cal_pend (cal_pend),
    .rdata    (reg_rdata),
    .cfg_q    (cfg_q),
    .clk_q    (clk_q),
    .freq_q   (freq_word),
    .rs_start (rs_start),
    .rs_use_us(rs_use_us),
    .cal_trig (cal_trig)
  );

  codec_resync_timer #(.SP_LEN(RESYNC_SP), .US_LEN(DIRECT_US)) u_resync (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (rs_start),
    .use_us   (rs_use_us),
    .sp_strobe(sp_strobe),
    .us_tick  (us_tick),
    .busy     (rs_busy)
  );

  codec_cal_seq #(.START_DLY(START_DLY), .CAL_LEN(CAL_LEN)) u_cal (
    .clk       (clk),
    .rst_n     (rst_n),
    .trig      (cal_trig),
    .sp_strobe (sp_strobe),
    .busy      (cal_busy),
    .pending   (cal_pend),
    .done_pulse(ofs_load)
  );

  assign clk_div     = clk_q[2:0];
  assign clk_src     = clk_q[3];
  assign xfer_hold   = cal_pend;
  assign dac_ignore  = cal_busy;
  assign adc_invalid = cal_busy;
endmodule

// File: rtl/codec_modecal_chk.sv
module codec_modecal_chk #(
  parameter int CAL_LEN = 384
) (
  input logic       clk,
  input logic       rst_n,
  input logic       sp_strobe,
  input logic       reg_wr,
  input logic       rs_busy,
  input logic [4:0] cfg_q,
  input logic       cal_busy,
  input logic       xfer_hold,
  input logic       dac_ignore,
  input logic       adc_invalid,
  input logic       ofs_load
);
  localparam int NW = $clog2(CAL_LEN + 2);
  logic [NW-1:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     run_cnt <= '0;
    else if (!cal_busy)             run_cnt <= '0;
    else if (sp_strobe)             run_cnt <= run_cnt + 1'b1;
  end

  assert_rise_on_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cal_busy) |-> $past(sp_strobe));

  assert_run_length_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cal_busy) |-> (run_cnt == NW'(CAL_LEN)));

  assert_hold_covers_cal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cal_busy |-> xfer_hold);

  assert_data_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cal_busy |-> (dac_ignore && adc_invalid));

  assert_write_dropped_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_busy && reg_wr) |=> $stable(cfg_q));

  assert_load_at_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cal_busy) |-> ofs_load);

  assert_load_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ofs_load |=> !ofs_load);
endmodule

bind codec_modecal_seq codec_modecal_chk #(.CAL_LEN(CAL_LEN)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sp_strobe  (sp_strobe),
  .reg_wr     (reg_wr),
  .rs_busy    (rs_busy),
  .cfg_q      (cfg_q),
  .cal_busy   (cal_busy),
  .xfer_hold  (xfer_hold),
  .dac_ignore (dac_ignore),
  .adc_invalid(adc_invalid),
  .ofs_load   (ofs_load)
);

// File: tb/tb_codec_modecal_seq.sv
module tb_codec_modecal_seq;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_idx = 3'd0;
  logic [7:0]  reg_wdata = 8'h00;
  logic [7:0]  reg_rdata;
  logic [2:0]  clk_div;
  logic        clk_src;
  logic [15:0] freq_word;
  logic        cal_busy, xfer_hold, dac_ignore, adc_invalid, ofs_load;
  logic [1:0]  sc = 2'd0;
  logic [1:0]  uc = 2'd0;
  logic        sp_strobe, us_tick;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    sc <= sc + 2'd1;
    uc <= (uc == 2'd2) ? 2'd0 : uc + 2'd1;
  end
  assign sp_strobe = (sc == 2'd3);
  assign us_tick   = (uc == 2'd2);

  codec_modecal_seq dut (
    .clk(clk), .rst_n(rst_n), .sp_strobe(sp_strobe), .us_tick(us_tick),
    .reg_wr(reg_wr), .reg_idx(reg_idx), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .clk_div(clk_div), .clk_src(clk_src), .freq_word(freq_word),
    .cal_busy(cal_busy), .xfer_hold(xfer_hold), .dac_ignore(dac_ignore),
    .adc_invalid(adc_invalid), .ofs_load(ofs_load)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Write lands on the posedge between the two negedges; returns at a negedge.
  task automatic wr(input logic [2:0] idx, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_idx = idx; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] idx, output logic [7:0] d);
    @(negedge clk);
    reg_idx = idx;
    #1 d = reg_rdata;
  endtask

  // Strobes before cal_busy rises, strobes while high, and offset loads seen.
  task automatic measure_cal(output int pre, output int len, output int loads, output bit flags_ok);
    pre = 0; len = 0; loads = 0; flags_ok = 1'b1;
    while (!cal_busy && pre < 20) begin
      if (sp_strobe) pre++;
      @(negedge clk);
    end
    while (cal_busy && len < 1000) begin
      if (!(adc_invalid && dac_ignore && xfer_hold)) flags_ok = 1'b0;
      if (ofs_load) loads++;
      if (sp_strobe) len++;
      @(negedge clk);
    end
    for (int k = 0; k < 8; k++) begin
      if (ofs_load) loads++;
      @(negedge clk);
    end
  endtask

  task automatic count_resync_sp(output int n);
    n = 0;
    while (reg_rdata == 8'h80 && n < 1000) begin
      if (sp_strobe) n++;
      @(negedge clk);
    end
  endtask

  task automatic count_resync_us(output int n);
    n = 0;
    while (reg_rdata == 8'h80 && n < 1000) begin
      if (us_tick) n++;
      @(negedge clk);
    end
  endtask

  function automatic logic [7:0] exp_cfg_rd(input logic [4:0] c);
    return {3'b000, c};
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int pre, len, loads, n;
    bit fl, seen;
    logic [7:0] d;
    logic [7:0] fhi_m, flo_m;
    logic [4:0] cfg_m;
    void'($urandom(32'd20240611));

    // Reset state
    repeat (3) @(negedge clk);
    reg_idx = 3'd0;
    #1;
    check(reg_rdata == 8'h03, "R1 cfg reset", reg_rdata, 8'h03);
    check(cal_busy == 1'b0, "R1 busy low in reset", cal_busy, 0);
    check(xfer_hold == 1'b1, "R4 hold while power-up cal pending", xfer_hold, 1);
    @(negedge clk);
    rst_n = 1'b1;

    // Power-up calibration
    measure_cal(pre, len, loads, fl);
    check(pre == 3, "R1 R3 power-up start delay", pre, 3);
    check(len == 384, "R3 power-up busy length", len, 384);
    check(loads == 1, "R10 power-up offset load", loads, 1);
    check(fl, "R5 R4 flags during power-up cal", fl, 1);

    // Resync on the mode-change path
    wr(3'd1, 8'h0D);
    count_resync_sp(n);
    check(n == 64, "R8 resync length in strobes", n, 64);
    #1;
    check(reg_rdata == 8'h0D, "R6 clock reg readback", reg_rdata, 8'h0D);
    check(clk_div == 3'd5 && clk_src == 1'b1, "R6 clock outputs", {clk_src, clk_div}, 4'hD);

    // Writes during resync are dropped, including a calibration trigger
    wr(3'd1, 8'h02);
    wr(3'd0, 8'h02);
    count_resync_sp(n);
    rd(3'd0, d);
    check(d == 8'h03, "R7 cfg write dropped during resync", d, 8'h03);
    seen = 1'b0;
    repeat (48) begin @(negedge clk); if (cal_busy || xfer_hold) seen = 1'b1; end
    check(!seen, "R7 dropped trigger starts no calibration", seen, 0);
    check(clk_div == 3'd2 && clk_src == 1'b0, "R6 second clock write", {clk_src, clk_div}, 4'h2);

    // Clearing mode-change with autocalibrate clear: offsets kept
    wr(3'd0, 8'h00);
    seen = 1'b0;
    repeat (48) begin @(negedge clk); if (cal_busy || xfer_hold || ofs_load) seen = 1'b1; end
    check(!seen, "R2 no calibration when autocal clear", seen, 0);

    // Direct path, timed in microsecond ticks
    wr(3'd1, 8'h07);
    count_resync_us(n);
    check(n == 200, "R9 direct resync length in ticks", n, 200);

    // Direct path with skip-wait: ready at once
    wr(3'd0, 8'h04);
    wr(3'd1, 8'h0A);
    reg_idx = 3'd1;
    #1;
    check(reg_rdata == 8'h0A, "R9 skip-wait no busy", reg_rdata, 8'h0A);

    // Random frequency and clock writes under random mode bits
    cfg_m = 5'b00100; fhi_m = 8'h00; flo_m = 8'h00;
    for (int i = 0; i < 30; i++) begin
      logic [7:0] a, b, c;
      cfg_m = {$urandom_range(1, 0) == 1, $urandom_range(1, 0) == 1, 1'b1, 1'b0, 1'b0};
      wr(3'd0, {3'b000, cfg_m});
      a = 8'($urandom); b = 8'($urandom); c = 8'($urandom);
      wr(3'd2, a);
      wr(3'd3, b);
      if (cfg_m[3] && cfg_m[4]) begin fhi_m = a; flo_m = b; end
      wr(3'd1, c);
      #1;
      check(freq_word == {fhi_m, flo_m}, "R11 freq word", freq_word, {fhi_m, flo_m});
      check({clk_src, clk_div} == c[3:0], "R6 random clock write", {clk_src, clk_div}, c[3:0]);
      rd(3'd2, d);
      check(d == fhi_m, "R11 upper byte readback", d, fhi_m);
      rd(3'd0, d);
      check(d == exp_cfg_rd(cfg_m), "R11 cfg readback", d, exp_cfg_rd(cfg_m));
    end

    // Calibration via the mode-change path
    wr(3'd0, 8'h03);
    wr(3'd0, 8'h02);
    check(xfer_hold == 1'b1, "R4 hold right after trigger", xfer_hold, 1);
    measure_cal(pre, len, loads, fl);
    check(pre == 3, "R2 R3 start delay after trigger", pre, 3);
    check(len == 384, "R3 busy length after trigger", len, 384);
    check(loads == 1, "R10 offset load after trigger", loads, 1);
    check(fl, "R5 flags during triggered cal", fl, 1);

    // Retrigger while running is ignored; status register
    wr(3'd0, 8'h03);
    wr(3'd0, 8'h02);
    rd(3'd4, d);
    check(d[1] == 1'b1, "R12 status pending bit", d, 8'h02);
    wr(3'd0, 8'h03);
    wr(3'd0, 8'h02);
    loads = 0; n = 0;
    while (!cal_busy && n < 100) begin @(negedge clk); n++; end
    rd(3'd4, d);
    check(d == 8'h03, "R12 status busy and pending", d, 8'h03);
    n = 0;
    while (cal_busy && n < 3000) begin
      @(negedge clk); n++;
      if (ofs_load) loads++;
    end
    seen = 1'b0;
    repeat (64) begin
      @(negedge clk);
      if (ofs_load) loads++;
      if (cal_busy || xfer_hold) seen = 1'b1;
    end
    check(!seen, "R12 retrigger ignored", seen, 0);
    check(loads == 1, "R12 R10 single load", loads, 1);
    rd(3'd4, d);
    check(d == 8'h00, "R12 status idle", d, 8'h00);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule